// File: doc/BRIEF.md
# Three-Digit Seven-Segment Scan Driver

This block lights three decimal digits (ones, tens, hundreds) on a display whose digits share one seven-segment bus. Only one digit is enabled at a time. The block rotates through four time slots at a fixed dwell time. Three of the slots each show one digit. The fourth slot turns everything off, which gives a short blanking gap before the rotation starts again. At the default rate of one slot per millisecond, the display looks steady to the eye.

The three BCD digits are plain inputs, sampled on every clock. The block drives a single registered 11-bit word. The upper four bits are active-low digit enables and the lower seven bits are active-low segment levels. All eleven bits change together on one clock edge. The dwell length is a parameter, so a simulation can use only a few cycles per slot.

Top module: `seg_digit_scan`

## Requirements
- R1: The output word carries the digit-enable field in bits 10:7. Bits 6:0 carry the segments, with segment a in bit 6, then b, c, d, e and f, down to segment g in bit 0. Every bit is active-low.
- R2: Each slot holds the output for exactly DWELL_CYCLES clock cycles. The default is 50000 cycles, which is 1 ms at 50 MHz.
- R3: The slot order is 0, 1, 2, 3 and then back to 0. Slot 0 is the first slot shown after reset.
- R4: The enable field is 0111 in slot 0 (ones digit), 1011 in slot 1 (tens digit) and 1101 in slot 2 (hundreds digit).
- R5: In slot 3 all eleven output bits are 1, so the display is blank.
- R6: The segment field shows these digit values as follows: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R7: A digit input from 10 to 15 is shown with the pattern for 0 (0000001).
- R8: The output is registered. A change on a digit input appears at the output after the next rising clock edge, while that digit's slot is active.
- R9: The reset is synchronous and active-high. The rising edge that samples it sets the output to all ones and clears the dwell counter and the slot index. After release, slot 0 is shown for a full dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active-high |
| ones_i | input | 4 | BCD ones digit |
| tens_i | input | 4 | BCD tens digit |
| hund_i | input | 4 | BCD hundreds digit |
| disp_o | output | 11 | Enables in bits 10:7, segments in bits 6:0, all active-low |

## Verification
Suppose the dwell counter stops one cycle early or late. The first slot boundary after reset then moves, and the enable field changes one sample away from the expected cycle. This shows up within the first DWELL_CYCLES+1 edges.

Suppose the slot index skips a slot or wraps at the wrong point. The bench then sees a wrong enable pattern, or a missing blank slot, within one full rotation of four dwells.

A fault in the decode appears as soon as the affected digit is shown. Each vector shows every digit slot, and the vectors cover all sixteen input codes, so a single wrong pattern is seen within the first rotation of its vector.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
   localparam int SEG_W    = 7;
   localparam int SEL_W    = 4;
   localparam int WORD_W   = SEL_W + SEG_W;
   localparam int BCD_W    = 4;
   localparam int NUM_SLOT = 4;
   localparam int SLOT_W   = $clog2(NUM_SLOT);

   typedef logic [SLOT_W-1:0] slot_t;
   typedef logic [SEG_W-1:0]  seg_t;
   typedef logic [SEL_W-1:0]  sel_t;

   // enable field per slot (active-low, one digit lit)
   localparam sel_t SEL_ONES  = 4'b0111;
   localparam sel_t SEL_TENS  = 4'b1011;
   localparam sel_t SEL_HUND  = 4'b1101;
   localparam sel_t SEL_BLANK = 4'b1111;
   localparam seg_t SEG_BLANK = 7'b1111111;
   localparam logic [WORD_W-1:0] WORD_BLANK = {SEL_BLANK, SEG_BLANK};
endpackage

// File: rtl/seg_scan_tick.sv
module seg_scan_tick #(
   parameter int DWELL_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int CNT_W = (DWELL_CYCLES > 2) ? $clog2(DWELL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYCLES - 1);

   generate
      if (DWELL_CYCLES < 2) begin : g_bad_dwell
         initial $error("seg_scan_tick: DWELL_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                  cnt_q <= '0;
      else if (cnt_q == CNT_LAST) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == CNT_LAST) && !rst;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_LAST); // R2
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/seg_scan_slot.sv
module seg_scan_slot
   import seg_scan_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  tick_i,
   output slot_t slot_o
);
   localparam slot_t SLOT_LAST = slot_t'(NUM_SLOT - 1);

   slot_t slot_q;

   always_ff @(posedge clk) begin
      if (rst)         slot_q <= '0;
      else if (tick_i) slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
   end

   assign slot_o = slot_q;

   AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      tick_i |=> (slot_q == (($past(slot_q) == SLOT_LAST) ? slot_t'(0) : slot_t'($past(slot_q) + 1'b1)))); // R3
   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(slot_q)); // R3
endmodule

// File: rtl/seg_bcd_decode.sv
module seg_bcd_decode
   import seg_scan_pkg::*;
(
   input  logic [BCD_W-1:0] bcd_i,
   output seg_t             seg_o
);
   always_comb begin
      unique case (bcd_i)
         4'd1:    seg_o = 7'b1001111;
         4'd2:    seg_o = 7'b0010010;
         4'd3:    seg_o = 7'b0000110;
         4'd4:    seg_o = 7'b1001100;
         4'd5:    seg_o = 7'b0100100;
         4'd6:    seg_o = 7'b0100000;
         4'd7:    seg_o = 7'b0001111;
         4'd8:    seg_o = 7'b0000000;
         4'd9:    seg_o = 7'b0000100;
         default: seg_o = 7'b0000001; // zero and codes 10..15
      endcase
   end
endmodule

// File: rtl/seg_digit_scan.sv
module seg_digit_scan
   import seg_scan_pkg::*;
#(
   parameter int DWELL_CYCLES = 50000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BCD_W-1:0]  ones_i,
   input  logic [BCD_W-1:0]  tens_i,
   input  logic [BCD_W-1:0]  hund_i,
   output logic [WORD_W-1:0] disp_o
);
   logic              tick;
   slot_t             slot;
   logic [BCD_W-1:0]  digit_sel;
   sel_t              en_sel;
   seg_t              seg_dec;
   logic [WORD_W-1:0] word_d;
   logic [WORD_W-1:0] word_q;

   seg_scan_tick #(.DWELL_CYCLES(DWELL_CYCLES)) u_tick (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   seg_scan_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .slot_o (slot)
   );

   // pick the digit first, then decode once
   always_comb begin
      unique case (slot)
         2'd0:    begin digit_sel = ones_i; en_sel = SEL_ONES;  end
         2'd1:    begin digit_sel = tens_i; en_sel = SEL_TENS;  end
         2'd2:    begin digit_sel = hund_i; en_sel = SEL_HUND;  end
         default: begin digit_sel = '0;     en_sel = SEL_BLANK; end
      endcase
   end

   seg_bcd_decode u_dec (
      .bcd_i (digit_sel),
      .seg_o (seg_dec)
   );

   assign word_d = (slot == slot_t'(NUM_SLOT - 1)) ? WORD_BLANK : {en_sel, seg_dec};

   always_ff @(posedge clk) begin
      if (rst) word_q <= WORD_BLANK;
      else     word_q <= word_d;
   end

   assign disp_o = word_q;

   AST_ONE_DIGIT_LIT: assert property (@(posedge clk) disable iff (rst)
      $countones(~word_q[WORD_W-1:SEG_W]) <= 1); // R4
   AST_BLANK_SLOT: assert property (@(posedge clk) disable iff (rst)
      (slot == slot_t'(NUM_SLOT - 1)) |=> (word_q == WORD_BLANK)); // R5
   AST_RESET_BLANK: assert property (@(posedge clk)
      rst |=> (word_q == WORD_BLANK)); // R9
endmodule

// File: tb/seg_digit_scan_test.sv
`timescale 1ns/1ps
module seg_digit_scan_test;
   localparam int D = 4;
   localparam int NVEC = 6;
   // each entry: {hundreds, tens, ones}
   localparam logic [11:0] VEC [NVEC] = '{12'h123, 12'h907, 12'h458, 12'h6AB, 12'hCDE, 12'hF00};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  ones = '0, tens = '0, hund = '0;
   logic [10:0] disp;
   int          nchk = 0;
   int          nbad = 0;

   always #2 clk = ~clk;

   seg_digit_scan #(.DWELL_CYCLES(D)) uut (
      .clk(clk), .rst(rst), .ones_i(ones), .tens_i(tens), .hund_i(hund), .disp_o(disp)
   );

   function automatic logic [6:0] pat(input logic [3:0] v);
      logic [6:0] t [10] = '{7'b0000001, 7'b1001111, 7'b0010010, 7'b0000110, 7'b1001100,
                             7'b0100100, 7'b0100000, 7'b0001111, 7'b0000000, 7'b0000100};
      return (v > 4'd9) ? t[0] : t[v];   // R6, R7
   endfunction

   function automatic logic [10:0] expw(input int s);
      case (s)
         0: return {4'b0111, pat(ones)};
         1: return {4'b1011, pat(tens)};
         2: return {4'b1101, pat(hund)};
         default: return 11'h7FF;
      endcase
   endfunction

   task automatic check(input string req, input logic [10:0] exp);
      nchk++;
      if (disp !== exp) begin
         nbad++;
         $display("FAIL %s: got %b expected %b at %0t", req, disp, exp, $time);
      end
   endtask

   task automatic run_frame(input logic [11:0] v);
      @(negedge clk); rst = 1'b1; {hund, tens, ones} = v;
      @(negedge clk); check("R9 reset blanks", 11'h7FF);
      rst = 1'b0;
      for (int s = 0; s < 5; s++)
         for (int c = 0; c < D; c++) begin
            @(negedge clk);
            check("R1 R2 R3 R4 R5 R6 R7 slot walk", expw(s % 4));
         end
   endtask

   initial begin
      #(200000 * 4);
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R9 initial reset state", 11'h7FF);
      for (int i = 0; i < NVEC; i++) run_frame(VEC[i]);

      // R8: mid-slot digit change seen after one edge
      run_frame(12'h321);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      @(negedge clk); check("R8 slot0 before change", {4'b0111, pat(4'd1)});
      ones = 4'd7;
      check("R8 no change before edge", {4'b0111, pat(4'd1)});
      @(negedge clk); check("R8 new ones digit", {4'b0111, 7'b0001111});
      repeat (D - 1) @(negedge clk);
      tens = 4'd5;
      @(negedge clk); check("R8 new tens digit", {4'b1011, 7'b0100100});

      // R9: reset in the middle of slot 2 restarts at slot 0 with full dwell
      repeat (D + 1) @(negedge clk);
      rst = 1'b1;
      @(negedge clk); check("R9 mid-scan reset", 11'h7FF);
      rst = 1'b0;
      for (int c = 0; c < D; c++) begin
         @(negedge clk); check("R9 full slot0 dwell", {4'b0111, pat(4'd7)});
      end
      @(negedge clk); check("R9 then slot1", {4'b1011, pat(4'd5)});

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule